// File: doc/BRIEF.md
# Two-level software-filled branch target predictor

This block sits in the fetch stage and turns each fetch address into a next fetch address. The first level is a small, fully associative buffer of four branch targets. It is filled only by an explicit hint operation that gives a branch address and its target. A hit in this buffer redirects fetch in the same cycle, so a correctly predicted taken branch costs no bubble. The hint can also flag a branch as statically easy. A flagged branch is then kept out of the second level.

The second level is a larger, direct-mapped table. Each entry holds a branch tag, a target and its own 4-bit outcome history. The history is combined with one address bit to index shared tables of 2-bit saturating counters. Its prediction is registered, so it appears as a late redirect one fetch cycle after the lookup. It is suppressed whenever the first level hit. Branch resolutions train the second level. Each resolution also reports a mispredict redirect with the correct address.

Top module: `sbp_predictor`

## Requirements
- R1: After reset both levels are empty and every counter holds 01 (weakly not taken). l1_hit_o, late_redirect_o and redirect_o are 0, and next_pc_o is fetch_pc_i + 4.
- R2: When fetch_valid_i is set and fetch_pc_i equals an address held in the first level, l1_hit_o is 1 and next_pc_o is its target in the same cycle. Otherwise l1_hit_o is 0 and next_pc_o is fetch_pc_i + 4.
- R3: A hint write to an address not already held fills the entry at a round-robin pointer (0,1,2,3,0,...) and advances the pointer, so the fifth distinct hint replaces the first. A hint write to an address already held rewrites that entry's target and easy flag in place and leaves the pointer alone.
- R4: A hint write takes effect from the next cycle. A fetch in the same cycle sees the previous contents.
- R5: When a fetch is valid, misses the first level, hits the second level, and the selected counter has its upper bit set, late_redirect_o is 1 in the next cycle and late_target_o is the stored target. A first-level hit suppresses late_redirect_o.
- R6: The second level is indexed by pc[4:2] and tagged by pc[15:5]. The counter used is counter[{pc[2], history}], with history bit 0 the newest outcome. Counters saturate at 00 and 11.
- R7: A resolution that hits the second level updates counter[{pc[2], history}] toward the outcome and then shifts the outcome into history bit 0. If the branch was taken, the stored target is replaced by the resolved target. A taken resolution that misses allocates the entry with history 0001 and the resolved target. A not-taken miss changes nothing.
- R8: A resolution whose address is held in the first level with the easy flag set leaves the second level and the counters untouched.
- R9: One cycle after a resolution whose predicted direction differs, or whose predicted target differs on a taken branch, redirect_o is 1. redirect_pc_o is then the resolved target if the branch was taken, else res_pc_i + 4. Otherwise redirect_o is 0.
- R10: A fetch in the same cycle as a resolution reads the state from before that resolution's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_pc_i | input | 16 | Fetch address |
| next_pc_o | output | 16 | Next fetch address from the first level or sequential |
| l1_hit_o | output | 1 | First-level hit this cycle |
| late_redirect_o | output | 1 | Second-level taken prediction for the previous fetch |
| late_target_o | output | 16 | Target for the late redirect |
| hint_we_i | input | 1 | Hint write into the first level |
| hint_pc_i | input | 16 | Branch address of the hint |
| hint_target_i | input | 16 | Branch target of the hint |
| hint_easy_i | input | 1 | Keep this branch out of the second level |
| res_valid_i | input | 1 | Branch resolution valid |
| res_pc_i | input | 16 | Resolved branch address |
| res_taken_i | input | 1 | Resolved direction |
| res_target_i | input | 16 | Resolved target |
| res_pred_taken_i | input | 1 | Direction that was predicted |
| res_pred_target_i | input | 16 | Target that was predicted |
| redirect_o | output | 1 | Mispredict redirect |
| redirect_pc_o | output | 16 | Correct fetch address on a redirect |

## Verification
A fetch can fall in the same cycle as a hint write, a resolution, or both, and all three can name the same branch. The bench provokes this on purpose: it fetches an address while hinting it, and it fetches a branch while resolving it. A long random phase then mixes all three operations over a small, aliasing set of addresses. The bench keeps its own model, which updates only after the edge. Every output is judged against that model's state from before the edge, so any design that lets a write bypass into the same-cycle lookup is caught.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  localparam logic [1:0] CTR_INIT = 2'b01;

  function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/sbp_l1_buf.sv
module sbp_l1_buf #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              look_en_i,
  input  logic [ADDR_W-1:0] look_pc_i,
  output logic              look_hit_o,
  output logic [ADDR_W-1:0] look_tgt_o,
  input  logic [ADDR_W-1:0] chk_pc_i,
  output logic              chk_easy_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_pc_i,
  input  logic [ADDR_W-1:0] wr_tgt_i,
  input  logic              wr_easy_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             vld_q, easy_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] pc_q, tgt_q;
  logic [PTR_W-1:0]               ptr_q;
  logic [ENTRIES-1:0]             wr_match;

  always_comb begin
    look_hit_o = 1'b0;
    look_tgt_o = '0;
    chk_easy_o = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_en_i && vld_q[i] && pc_q[i] == look_pc_i) begin
        look_hit_o = 1'b1;
        look_tgt_o = tgt_q[i];
      end
      if (vld_q[i] && easy_q[i] && pc_q[i] == chk_pc_i) chk_easy_o = 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign wr_match[g] = vld_q[g] && pc_q[g] == wr_pc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      easy_q <= '0;
      pc_q   <= '0;
      tgt_q  <= '0;
      ptr_q  <= '0;
    end else if (wr_en_i) begin
      if (|wr_match) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (wr_match[i]) begin
            tgt_q[i]  <= wr_tgt_i;
            easy_q[i] <= wr_easy_i;
          end
        end
      end else begin
        vld_q[ptr_q]  <= 1'b1;
        pc_q[ptr_q]   <= wr_pc_i;
        tgt_q[ptr_q]  <= wr_tgt_i;
        easy_q[ptr_q] <= wr_easy_i;
        ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sbp_bk_tbl.sv
module sbp_bk_tbl #(
  parameter int PC_W   = 14,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int HIST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   rd_pc_i,
  output logic              rd_hit_o,
  output logic [ADDR_W-1:0] rd_tgt_o,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic [PC_W-1:0]   up_pc_i,
  output logic              up_hit_o,
  output logic [HIST_W-1:0] up_hist_o,
  input  logic              up_en_i,
  input  logic              alloc_en_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W;

  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0][ADDR_W-1:0] tgt_q;
  logic [DEPTH-1:0][HIST_W-1:0] hist_q;

  logic [IDX_W-1:0] rd_idx, up_idx;
  assign rd_idx = rd_pc_i[IDX_W-1:0];
  assign up_idx = up_pc_i[IDX_W-1:0];

  assign rd_hit_o  = vld_q[rd_idx] && tag_q[rd_idx] == rd_pc_i[PC_W-1:IDX_W];
  assign rd_tgt_o  = tgt_q[rd_idx];
  assign rd_hist_o = hist_q[rd_idx];
  assign up_hit_o  = vld_q[up_idx] && tag_q[up_idx] == up_pc_i[PC_W-1:IDX_W];
  assign up_hist_o = hist_q[up_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      tag_q  <= '0;
      tgt_q  <= '0;
      hist_q <= '0;
    end else if (up_en_i) begin
      hist_q[up_idx] <= {hist_q[up_idx][HIST_W-2:0], taken_i};
      if (taken_i) tgt_q[up_idx] <= target_i;
    end else if (alloc_en_i) begin
      vld_q[up_idx]  <= 1'b1;
      tag_q[up_idx]  <= up_pc_i[PC_W-1:IDX_W];
      tgt_q[up_idx]  <= target_i;
      hist_q[up_idx] <= HIST_W'(1);
    end
  end
endmodule

// File: rtl/sbp_pht.sv
module sbp_pht #(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [1:0]       rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             taken_i
);
  import sbp_pkg::*;
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][1:0] ctr_q;
  assign rd_ctr_o = ctr_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= ctr_next(ctr_q[wr_idx_i], taken_i);
    end
  end
endmodule

// File: rtl/sbp_predictor.sv
module sbp_predictor #(
  parameter int ADDR_W     = 16,
  parameter int L1_ENTRIES = 4,
  parameter int BK_IDX_W   = 3,
  parameter int HIST_W     = 4,
  parameter int SEL_W      = 1,
  parameter int ALIGN      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              l1_hit_o,
  output logic              late_redirect_o,
  output logic [ADDR_W-1:0] late_target_o,
  input  logic              hint_we_i,
  input  logic [ADDR_W-1:0] hint_pc_i,
  input  logic [ADDR_W-1:0] hint_target_i,
  input  logic              hint_easy_i,
  input  logic              res_valid_i,
  input  logic [ADDR_W-1:0] res_pc_i,
  input  logic              res_taken_i,
  input  logic [ADDR_W-1:0] res_target_i,
  input  logic              res_pred_taken_i,
  input  logic [ADDR_W-1:0] res_pred_target_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);
  localparam int PC_W  = ADDR_W - ALIGN;
  localparam int PHT_W = SEL_W + HIST_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ALIGN);

  logic              l1_hit;
  logic [ADDR_W-1:0] l1_tgt;
  logic              res_easy;
  logic              bk_hit, up_hit;
  logic [ADDR_W-1:0] bk_tgt;
  logic [HIST_W-1:0] bk_hist, up_hist;
  logic [1:0]        rd_ctr;
  logic              do_res, up_en, alloc_en, mispred;

  sbp_l1_buf #(.ADDR_W(ADDR_W), .ENTRIES(L1_ENTRIES)) u_l1 (
    .clk_i, .rst_ni,
    .look_en_i (fetch_valid_i),
    .look_pc_i (fetch_pc_i),
    .look_hit_o(l1_hit),
    .look_tgt_o(l1_tgt),
    .chk_pc_i  (res_pc_i),
    .chk_easy_o(res_easy),
    .wr_en_i   (hint_we_i),
    .wr_pc_i   (hint_pc_i),
    .wr_tgt_i  (hint_target_i),
    .wr_easy_i (hint_easy_i)
  );

  sbp_bk_tbl #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(BK_IDX_W), .HIST_W(HIST_W)) u_bk (
    .clk_i, .rst_ni,
    .rd_pc_i   (fetch_pc_i[ADDR_W-1:ALIGN]),
    .rd_hit_o  (bk_hit),
    .rd_tgt_o  (bk_tgt),
    .rd_hist_o (bk_hist),
    .up_pc_i   (res_pc_i[ADDR_W-1:ALIGN]),
    .up_hit_o  (up_hit),
    .up_hist_o (up_hist),
    .up_en_i   (up_en),
    .alloc_en_i(alloc_en),
    .taken_i   (res_taken_i),
    .target_i  (res_target_i)
  );

  sbp_pht #(.IDX_W(PHT_W)) u_pht (
    .clk_i, .rst_ni,
    .rd_idx_i({fetch_pc_i[ALIGN +: SEL_W], bk_hist}),
    .rd_ctr_o(rd_ctr),
    .wr_en_i (up_en),
    .wr_idx_i({res_pc_i[ALIGN +: SEL_W], up_hist}),
    .taken_i (res_taken_i)
  );

  assign l1_hit_o  = l1_hit;
  assign next_pc_o = l1_hit ? l1_tgt : fetch_pc_i + STEP;

  assign do_res   = res_valid_i && !res_easy;
  assign up_en    = do_res && up_hit;
  assign alloc_en = do_res && !up_hit && res_taken_i;
  assign mispred  = (res_pred_taken_i != res_taken_i) ||
                    (res_taken_i && res_pred_target_i != res_target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      late_redirect_o <= 1'b0;
      late_target_o   <= '0;
      redirect_o      <= 1'b0;
      redirect_pc_o   <= '0;
    end else begin
      late_redirect_o <= fetch_valid_i && !l1_hit && bk_hit && rd_ctr[1];
      late_target_o   <= bk_tgt;
      redirect_o      <= res_valid_i && mispred;
      redirect_pc_o   <= res_taken_i ? res_target_i : res_pc_i + STEP;
    end
  end
endmodule

// File: rtl/sbp_predictor_chk.sv
module sbp_predictor_chk #(
  parameter int ADDR_W = 16,
  parameter int ALIGN  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_valid_i,
  input logic [ADDR_W-1:0] fetch_pc_i,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              l1_hit_o,
  input logic              late_redirect_o,
  input logic              res_valid_i,
  input logic              res_taken_i,
  input logic [ADDR_W-1:0] res_target_i,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] redirect_pc_o
);
  // R2
  l1_hit_needs_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l1_hit_o |-> fetch_valid_i);
  // R2
  seq_next_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && !l1_hit_o) |-> next_pc_o == fetch_pc_i + ADDR_W'(1 << ALIGN));
  // R5
  late_after_l1_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_redirect_o |-> ($past(fetch_valid_i) && !$past(l1_hit_o)));
  // R9
  redirect_needs_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> $past(res_valid_i));
  // R9
  redirect_taken_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && $past(res_taken_i)) |-> redirect_pc_o == $past(res_target_i));
endmodule

bind sbp_predictor sbp_predictor_chk #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_chk (
  .clk_i, .rst_ni, .fetch_valid_i, .fetch_pc_i, .next_pc_o, .l1_hit_o,
  .late_redirect_o, .res_valid_i, .res_taken_i, .res_target_i,
  .redirect_o, .redirect_pc_o
);

// File: tb/sbp_predictor_bench.sv
module sbp_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0, hw = 1'b0, he = 1'b0, rv = 1'b0, rt = 1'b0, rpt = 1'b0;
  logic [15:0] fpc = '0, hpc = '0, htg = '0, rpc = '0, rtg = '0, rptg = '0;
  logic [15:0] next_pc, late_tgt, redir_pc;
  logic        l1_hit, late, redir;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  sbp_predictor u_sbp_predictor (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fv), .fetch_pc_i(fpc), .next_pc_o(next_pc), .l1_hit_o(l1_hit),
    .late_redirect_o(late), .late_target_o(late_tgt),
    .hint_we_i(hw), .hint_pc_i(hpc), .hint_target_i(htg), .hint_easy_i(he),
    .res_valid_i(rv), .res_pc_i(rpc), .res_taken_i(rt), .res_target_i(rtg),
    .res_pred_taken_i(rpt), .res_pred_target_i(rptg),
    .redirect_o(redir), .redirect_pc_o(redir_pc)
  );

  // reference state
  logic        m_vld[4], m_easy[4];
  logic [15:0] m_pc[4], m_tg[4];
  int          m_ptr;
  logic        b_vld[8];
  logic [10:0] b_tag[8];
  logic [15:0] b_tg[8];
  logic [3:0]  b_hist[8];
  logic [1:0]  pht[32];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_easy[i] = 0; m_pc[i] = 0; m_tg[i] = 0; end
    for (int i = 0; i < 8; i++) begin b_vld[i] = 0; b_tag[i] = 0; b_tg[i] = 0; b_hist[i] = 0; end
    for (int i = 0; i < 32; i++) pht[i] = 2'b01;
    m_ptr = 0;
  endtask

  // one clock: drive at negedge, judge combinational now, registered after the edge
  task automatic cyc(input logic f_v, input logic [15:0] f_pc,
                     input logic h_w, input logic [15:0] h_pc, input logic [15:0] h_tg, input logic h_e,
                     input logic r_v, input logic [15:0] r_pc, input logic r_t, input logic [15:0] r_tg,
                     input logic r_pt, input logic [15:0] r_ptg, input string tag);
    logic hit, easy, e_late, e_red, mis;
    logic [15:0] tg, e_ltg, e_rpc;
    int bi, ri, pi, match;
    fv = f_v; fpc = f_pc; hw = h_w; hpc = h_pc; htg = h_tg; he = h_e;
    rv = r_v; rpc = r_pc; rt = r_t; rtg = r_tg; rpt = r_pt; rptg = r_ptg;
    #1;
    hit = 0; tg = 0; easy = 0;
    for (int i = 0; i < 4; i++) begin
      if (f_v && m_vld[i] && m_pc[i] == f_pc) begin hit = 1; tg = m_tg[i]; end
      if (m_vld[i] && m_easy[i] && m_pc[i] == r_pc) easy = 1;
    end
    chk("R2 hit", {15'b0, l1_hit}, {15'b0, hit});
    chk("R2 next_pc", next_pc, hit ? tg : f_pc + 16'd4);
    bi = (f_pc >> 2) & 7;
    pi = {f_pc[2], b_hist[bi]};
    e_late = f_v && !hit && b_vld[bi] && b_tag[bi] == f_pc[15:5] && pht[pi][1];
    e_ltg = b_tg[bi];
    mis = (r_pt != r_t) || (r_t && r_ptg != r_tg);
    e_red = r_v && mis;
    e_rpc = r_t ? r_tg : r_pc + 16'd4;
    // model update after the edge
    @(posedge clk);
    if (h_w) begin
      match = -1;
      for (int i = 0; i < 4; i++) if (m_vld[i] && m_pc[i] == h_pc) match = i;
      if (match >= 0) begin m_tg[match] = h_tg; m_easy[match] = h_e; end
      else begin
        m_vld[m_ptr] = 1; m_pc[m_ptr] = h_pc; m_tg[m_ptr] = h_tg; m_easy[m_ptr] = h_e;
        m_ptr = (m_ptr + 1) % 4;
      end
    end
    if (r_v && !easy) begin
      ri = (r_pc >> 2) & 7;
      if (b_vld[ri] && b_tag[ri] == r_pc[15:5]) begin
        pi = {r_pc[2], b_hist[ri]};
        if (r_t && pht[pi] != 2'b11) pht[pi] = pht[pi] + 1;
        if (!r_t && pht[pi] != 2'b00) pht[pi] = pht[pi] - 1;
        b_hist[ri] = {b_hist[ri][2:0], r_t};
        if (r_t) b_tg[ri] = r_tg;
      end else if (r_t) begin
        b_vld[ri] = 1; b_tag[ri] = r_pc[15:5]; b_tg[ri] = r_tg; b_hist[ri] = 4'b0001;
      end
    end
    @(negedge clk);
    chk(tag, {15'b0, late}, {15'b0, e_late});
    if (e_late) chk(tag, late_tgt, e_ltg);
    chk("R9 redirect", {15'b0, redir}, {15'b0, e_red});
    if (e_red) chk("R9 redirect_pc", redir_pc, e_rpc);
  endtask

  task automatic fetch(input logic [15:0] pc, input string tag);
    cyc(1, pc, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic hint(input logic [15:0] pc, input logic [15:0] tg, input logic e);
    cyc(0, 0, 1, pc, tg, e, 0, 0, 0, 0, 0, 0, "R3");
  endtask
  task automatic resolve(input logic [15:0] pc, input logic t, input logic [15:0] tg, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, pc, t, tg, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_reset();
    fpc = 16'h0040;
    #23;
    // R1: reset state
    chk("R1 l1_hit", {15'b0, l1_hit}, 16'd0);
    chk("R1 late", {15'b0, late}, 16'd0);
    chk("R1 redirect", {15'b0, redir}, 16'd0);
    chk("R1 next_pc", next_pc, 16'h0044);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 16; k++) fetch(16'h0100 + 16'(k * 4), "R1");

    // R3: fill five hints, fifth replaces entry 0
    for (int k = 0; k < 5; k++) hint(16'h0200 + 16'(k * 8), 16'h0800 + 16'(k * 16), 0);
    for (int k = 0; k < 6; k++) fetch(16'h0200 + 16'(k * 8), "R3");
    // R3: in-place rewrite, pointer unchanged
    hint(16'h0210, 16'h0abc, 0);
    hint(16'h0300, 16'h0ccc, 0);
    for (int k = 0; k < 6; k++) fetch(16'h0200 + 16'(k * 8), "R3");
    fetch(16'h0300, "R3");
    // R4: hint and fetch of the same address in one cycle
    cyc(1, 16'h0400, 1, 16'h0400, 16'h0444, 0, 0, 0, 0, 0, 0, 0, "R4");
    fetch(16'h0400, "R4");

    // R6 R7: train a branch in the second level, watching the late redirect
    for (int k = 0; k < 7; k++) begin
      resolve(16'h1104, 1, 16'h2000, "R7");
      fetch(16'h1104, "R6");
    end
    // R7: not-taken outcomes walk the counters back
    for (int k = 0; k < 6; k++) begin
      resolve(16'h1104, 0, 16'h2000, "R7");
      fetch(16'h1104, "R6");
    end
    // R7: aliasing tag replaces nothing on not-taken miss, allocates on taken
    resolve(16'h1124, 0, 16'h3000, "R7");
    fetch(16'h1124, "R7");
    resolve(16'h1124, 1, 16'h3000, "R7");
    fetch(16'h1104, "R7");
    // R10: fetch and resolve the same branch together
    for (int k = 0; k < 6; k++)
      cyc(1, 16'h1124, 0, 0, 0, 0, 1, 16'h1124, 1, 16'h3100, 0, 0, "R10");
    fetch(16'h1124, "R10");

    // R8: easy branch stays out of the second level, seen after eviction
    hint(16'h1508, 16'h1600, 1);
    for (int k = 0; k < 6; k++) resolve(16'h1508, 1, 16'h1600, "R8");
    for (int k = 0; k < 4; k++) hint(16'h0600 + 16'(k * 4), 16'h0700, 0);
    fetch(16'h1508, "R8");
    for (int k = 0; k < 6; k++) resolve(16'h1508, 1, 16'h1600, "R8");
    fetch(16'h1508, "R8");

    // R5: first level hit suppresses a trained second-level prediction
    hint(16'h1508, 16'h1700, 0);
    fetch(16'h1508, "R5");

    // R9: mispredict cases
    cyc(0, 0, 0, 0, 0, 0, 1, 16'h0900, 1, 16'h0a00, 1, 16'h0a00, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 16'h0900, 1, 16'h0a00, 1, 16'h0b00, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 16'h0900, 0, 16'h0a00, 1, 16'h0a00, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 16'h0900, 1, 16'h0a00, 0, 16'h0000, "R9");
    cyc(0, 0, 0, 0, 0, 0, 1, 16'h0904, 0, 16'h0a00, 0, 16'h0b00, "R9");

    // mixed sweep over a small aliasing address set
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a, b, c;
      int r;
      r = int'($urandom);
      a = 16'h1000 + 16'((r & 7) * 4) + ((r & 8) != 0 ? 16'h0020 : 16'h0000);
      b = 16'h1000 + 16'(((r >> 4) & 7) * 4) + ((r & 128) != 0 ? 16'h0020 : 16'h0000);
      c = 16'h2000 + 16'(((r >> 8) & 3) * 16);
      cyc(r[12], a,
          (r[15:13] == 3'd0), b, c, r[16],
          r[17], b, r[18], c, r[19], (r[20] ? c : 16'h2000),
          "R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule